// File: doc/BRIEF.md
# Demand-First Output Port Arbiter

This block is the second-stage switch allocator for one output port of a mesh router. Each input port offers at most one flit per cycle to this output, already chosen by that input's own virtual-channel stage. Every flit is marked as a head flit, a tail flit, or both. A head flit also carries a traffic-class bit: 0 for a demand packet and 1 for a speculative prefetch packet. The block latches the class from each head flit. Body and tail flits of the same packet reuse that latched class and ignore the class bit on their own lines.

Each cycle the block grants at most one input through a one-hot vector and a valid flag. Two round-robin arbiters evaluate in parallel. One sees demand requests and the other sees prefetch requests. The demand result takes precedence whenever any demand request exists. A per-input wait counter tracks how long a prefetch request has gone without a grant. When the counter reaches a programmable limit, that request moves into the demand pool. A packet that wins the output keeps it until its tail flit has passed, so packets never interleave.

Top module: `demand_first_out_arb`

## Requirements
- R1: After reset the grant is zero, grant_valid is low, both round-robin searches start at input 0, every wait counter is zero and every latched class is demand.
- R2: In a cycle with no req_valid bit set, grant is all zeros and grant_valid is low.
- R3: grant has at most one bit set. A set bit is always at an input whose req_valid is high. grant_valid is high exactly when grant is non-zero.
- R4: When req_head[i] is high, req_pf[i] (1 = prefetch, 0 = demand) sets the class of input i and is stored. When req_head[i] is low, req_pf[i] is ignored and the stored class applies.
- R5: Outside a held packet, if any valid request is demand-class or promoted, the grant goes to one of those requests and never to an unpromoted prefetch request.
- R6: The demand arbiter searches upward from its pointer, wrapping from N-1 to 0. When its result is used, the pointer moves to one past the granted input.
- R7: The prefetch arbiter uses a separate pointer under the same search rule. That pointer moves only in cycles where the prefetch result is the grant actually issued.
- R8: A granted flit with req_tail low locks the output to that input. While locked, only that input can be granted. In a locked cycle where that input is not valid, no grant is issued. Granting a flit with req_tail high releases the lock. A flit with both head and tail high never locks.
- R9: An input's wait counter increases by one in each cycle where it holds a valid prefetch-class request that is not granted, and stops at starve_limit. The counter returns to zero in a cycle where the input is granted, or where it has no valid prefetch-class request.
- R10: A prefetch-class request whose wait count has reached starve_limit is promoted. It competes in the demand pool under the demand pointer. With starve_limit 0, every prefetch request is promoted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| starve_limit | input | WAIT_W | Wait cycles before a prefetch request is promoted |
| req_valid | input | N_IN | Per-input flit request |
| req_head | input | N_IN | Flit is the head of its packet |
| req_tail | input | N_IN | Flit is the tail of its packet |
| req_pf | input | N_IN | Traffic class from a head flit (1 = prefetch) |
| grant | output | N_IN | One-hot grant |
| grant_valid | output | 1 | A grant is issued this cycle |

## Verification
The assertions check, on every cycle, that grants are one-hot and legal, that nothing is granted when nothing is requested, that unpromoted prefetch requests lose to demand, that a held packet keeps the output, that an idle arbiter's pointer stays where it is, and that wait counters step by at most one and stay promoted while still waiting. Only the bench scenarios can show the exact rotation order of each pointer, the effect of the latched class on body flits, the bubble cycle inside a held packet, and the cycle in which a starved request is first promoted and served. These are compared against a behavioural model on every cycle.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
    typedef enum logic {
        TC_DEMAND   = 1'b0,
        TC_PREFETCH = 1'b1
    } tclass_e;
endpackage

// File: rtl/dfa_rr_arb.sv
module dfa_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         take,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IW-1:0] ptr;
    } rr_state_t;

    rr_state_t st_d, st_q;
    logic      found;

    always_comb begin
        st_d  = st_q;
        gnt   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!found && req[(int'(st_q.ptr) + k) % N]) begin
                gnt[(int'(st_q.ptr) + k) % N] = 1'b1;
                found = 1'b1;
                if (take) st_d.ptr = IW'((int'(st_q.ptr) + k + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: only requesters are granted, at most one
    p_rr_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & ~req) == '0) && $onehot0(gnt));
    // R3: a non-empty request set always yields a winner
    p_rr_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));
    // R7: an arbiter whose result is unused keeps its pointer
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(st_q.ptr));
endmodule

// File: rtl/dfa_wait_ctr.sv
module dfa_wait_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pending,
    input  logic         granted,
    input  logic [W-1:0] limit,
    output logic         promoted
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } wc_state_t;

    wc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (granted || !pending)  st_d.cnt = '0;
        else if (st_q.cnt < limit) st_d.cnt = st_q.cnt + 1'b1;
        else                       st_d.cnt = limit;
        promoted = (st_q.cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: the count grows by at most one per cycle
    p_wait_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != {W{1'b1}}) |=> (st_q.cnt <= $past(st_q.cnt) + 1'b1));
    // R10: a promoted request still waiting stays promoted under a fixed limit
    p_promo_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (promoted && pending && !granted) ##1 $stable(limit) |-> promoted);
endmodule

// File: rtl/demand_first_out_arb.sv
module demand_first_out_arb #(
    parameter int N_IN   = 4,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] starve_limit,
    input  logic [N_IN-1:0]   req_valid,
    input  logic [N_IN-1:0]   req_head,
    input  logic [N_IN-1:0]   req_tail,
    input  logic [N_IN-1:0]   req_pf,
    output logic [N_IN-1:0]   grant,
    output logic              grant_valid
);
    import dfa_pkg::*;

    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

    typedef struct packed {
        logic                    lock;
        logic [IW-1:0]           lidx;
        tclass_e [N_IN-1:0]      cls;
    } top_state_t;

    top_state_t        st_d, st_q;
    tclass_e [N_IN-1:0] cls_eff;
    logic [N_IN-1:0]   pf_pend, dem_pool, pf_pool, promoted;
    logic [N_IN-1:0]   dem_gnt, pf_gnt;
    logic              use_dem, use_pf;
    logic [IW-1:0]     gidx;

    dfa_rr_arb #(.N(N_IN)) u_dem_arb (
        .clk(clk), .rst_n(rst_n), .req(dem_pool), .take(use_dem), .gnt(dem_gnt)
    );

    dfa_rr_arb #(.N(N_IN)) u_pf_arb (
        .clk(clk), .rst_n(rst_n), .req(pf_pool), .take(use_pf), .gnt(pf_gnt)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_wait
        dfa_wait_ctr #(.W(WAIT_W)) u_wait (
            .clk      (clk),
            .rst_n    (rst_n),
            .pending  (pf_pend[i]),
            .granted  (grant[i]),
            .limit    (starve_limit),
            .promoted (promoted[i])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_IN; i++) begin
            cls_eff[i]  = req_head[i] ? tclass_e'(req_pf[i]) : st_q.cls[i];
            pf_pend[i]  = req_valid[i] && (cls_eff[i] == TC_PREFETCH);
            dem_pool[i] = req_valid[i] && ((cls_eff[i] == TC_DEMAND) || promoted[i]);
            pf_pool[i]  = pf_pend[i] && !promoted[i];
            if (req_valid[i] && req_head[i]) st_d.cls[i] = tclass_e'(req_pf[i]);
        end

        use_dem = !st_q.lock && (|dem_pool);
        use_pf  = !st_q.lock && !(|dem_pool) && (|pf_pool);

        grant = '0;
        if (st_q.lock)    grant[st_q.lidx] = req_valid[st_q.lidx];
        else if (use_dem) grant = dem_gnt;
        else if (use_pf)  grant = pf_gnt;
        grant_valid = |grant;

        gidx = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (grant[i]) gidx = IW'(i);
        end

        if (grant_valid) begin
            if (st_q.lock) begin
                if (req_tail[st_q.lidx]) st_d.lock = 1'b0;
            end else if (!req_tail[gidx]) begin
                st_d.lock = 1'b1;
                st_d.lidx = gidx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: no requests, no grant
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == '0) |-> !grant_valid);
    // R3: one-hot grant to a valid requester, flag matches
    p_grant_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req_valid) == '0) && (grant_valid == (grant != '0)));
    // R5: unpromoted prefetch never beats a pending demand
    p_demand_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.lock && (dem_pool != '0)) |-> ((grant & pf_pool) == '0));
    // R8: a non-tail winner keeps the output next cycle
    p_hold_packet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && ((grant & ~req_tail) != '0)) |=> (!grant_valid || (grant == $past(grant))));
endmodule

// File: tb/demand_first_out_arb_test.sv
module demand_first_out_arb_test;
    localparam int N = 4;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] starve_limit;
    logic [N-1:0] req_valid, req_head, req_tail, req_pf;
    logic [N-1:0] grant;
    logic         grant_valid;

    int n_chk  = 0;
    int n_fail = 0;

    int m_dptr, m_pptr, m_lock, m_lidx;
    int m_wait [N];
    int m_cls  [N];

    always #2 clk = ~clk;

    demand_first_out_arb #(.N_IN(N), .WAIT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .starve_limit(starve_limit),
        .req_valid(req_valid), .req_head(req_head), .req_tail(req_tail), .req_pf(req_pf),
        .grant(grant), .grant_valid(grant_valid)
    );

    function automatic int rr_pick(input int ptr, input logic [N-1:0] mask);
        for (int k = 0; k < N; k++) begin
            if (mask[(ptr + k) % N]) return (ptr + k) % N;
        end
        return -1;
    endfunction

    task automatic cyc(input logic [N-1:0] v, h, t, p, input string tag);
        logic [N-1:0] dem, pf, ev;
        int eg, ce, lim;
        req_valid = v; req_head = h; req_tail = t; req_pf = p;
        #1;
        lim = int'(starve_limit);
        dem = '0; pf = '0;
        for (int i = 0; i < N; i++) begin
            ce = h[i] ? int'(p[i]) : m_cls[i];
            if (v[i] && (ce == 0 || m_wait[i] >= lim)) dem[i] = 1'b1;
            else if (v[i]) pf[i] = 1'b1;
        end
        eg = -1;
        if (m_lock != 0) begin
            if (v[m_lidx]) eg = m_lidx;
        end else if (dem != '0) begin
            eg = rr_pick(m_dptr, dem);
            m_dptr = (eg + 1) % N;
        end else if (pf != '0) begin
            eg = rr_pick(m_pptr, pf);
            m_pptr = (eg + 1) % N;
        end
        ev = '0;
        if (eg >= 0) ev[eg] = 1'b1;
        n_chk++;
        if (grant !== ev || grant_valid !== (eg >= 0)) begin
            n_fail++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                     tag, grant, grant_valid, ev, (eg >= 0));
        end
        for (int i = 0; i < N; i++) begin
            ce = h[i] ? int'(p[i]) : m_cls[i];
            if (eg == i || !(v[i] && ce == 1)) m_wait[i] = 0;
            else if (m_wait[i] < lim)          m_wait[i] = m_wait[i] + 1;
            else                               m_wait[i] = lim;
            if (v[i] && h[i]) m_cls[i] = int'(p[i]);
        end
        if (eg >= 0) begin
            if (m_lock != 0) begin
                if (t[m_lidx]) m_lock = 0;
            end else if (!t[eg]) begin
                m_lock = 1;
                m_lidx = eg;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; starve_limit = 8'd200;
        req_valid = '0; req_head = '0; req_tail = '0; req_pf = '0;
        m_dptr = 0; m_pptr = 0; m_lock = 0; m_lidx = 0;
        for (int i = 0; i < N; i++) begin m_wait[i] = 0; m_cls[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (grant !== '0 || grant_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: grant=%b valid=%b expected grant=0000 valid=0", grant, grant_valid);
        end
        rst_n = 1'b1;

        repeat (3) cyc(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R2");
        // R1 and R6: demand rotation starts at input 0
        repeat (6) cyc(4'b1111, 4'b1111, 4'b1111, 4'b0000, "R1/R3/R6");
        repeat (3) cyc(4'b1111, 4'b1111, 4'b1111, 4'b1011, "R5");
        repeat (4) cyc(4'b1011, 4'b1111, 4'b1111, 4'b1011, "R7");
        cyc(4'b0100, 4'b0100, 4'b0100, 4'b0000, "R7");
        repeat (3) cyc(4'b1011, 4'b1111, 4'b1111, 4'b1011, "R7");
        repeat (2) cyc(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R9");

        // R4: class latched from head, ignored on a later non-head flit
        cyc(4'b0001, 4'b0001, 4'b0001, 4'b0001, "R4");
        cyc(4'b0011, 4'b0010, 4'b0011, 4'b0000, "R4");
        cyc(4'b0001, 4'b0000, 4'b0001, 4'b0000, "R4");
        cyc(4'b0011, 4'b0011, 4'b0011, 4'b0000, "R4");

        // R8: packet held until tail, bubble inside packet
        cyc(4'b0001, 4'b0001, 4'b0000, 4'b0000, "R8");
        cyc(4'b0011, 4'b0010, 4'b0010, 4'b0000, "R8");
        cyc(4'b0010, 4'b0010, 4'b0010, 4'b0000, "R8");
        cyc(4'b0011, 4'b0010, 4'b0011, 4'b0000, "R8");
        cyc(4'b0010, 4'b0010, 4'b0010, 4'b0000, "R8");

        // R9/R10: starvation promotion
        starve_limit = 8'd3;
        repeat (12) cyc(4'b0111, 4'b0111, 4'b0111, 4'b0001, "R9/R10");
        starve_limit = 8'd2;
        repeat (2) cyc(4'b0011, 4'b0011, 4'b0011, 4'b0001, "R9");
        cyc(4'b0010, 4'b0010, 4'b0010, 4'b0000, "R9");
        repeat (4) cyc(4'b0011, 4'b0011, 4'b0011, 4'b0001, "R9");
        starve_limit = 8'd0;
        repeat (4) cyc(4'b0111, 4'b0111, 4'b0111, 4'b0011, "R10");
        repeat (2) cyc(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R2");

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule